// File: doc/BRIEF.md
# Channel LLR Fixed-Point Quantizer

This block turns soft channel values into the narrow integer log-likelihood format that an iterative parity-check decoder works on. Each input is a signed fixed-point LLR with a parameterised count of fractional bits. The block doubles the value and keeps only its integer part, truncating toward zero. It then saturates the result to a symmetric signed window. With the default 8-bit output, the stored word reads as a value with six integer bits and one fractional bit. The conversion runs once per value, ahead of decoding, so every later stage uses integer arithmetic only.

Values stream in and out through a valid/ready handshake. One register stage sits between the two sides and carries the valid flag along with the data. A new value can be taken in the same cycle as the held one leaves, so a steady stream passes at one value per clock.

Top module: `llr_quant`

## Requirements
- R1: During reset and in the first cycle after it, out_valid is 0 and in_ready is 1.
- R2: For a non-negative input x (signed, FRAC_W fractional bits), the output is floor(x / 2^(FRAC_W-1)) when that value is at most 2^(OUT_W-1)-1. With FRAC_W=0 the output is 2x.
- R3: For a negative input whose discarded low bits are not all zero, the output is truncated toward zero (for example, with FRAC_W=4, x=-1 gives 0 and x=-9 gives -1).
- R4: For a negative input that is an exact multiple of 2^(FRAC_W-1), the output is exactly x / 2^(FRAC_W-1) (for example, x=-8 gives -1).
- R5: A scaled value above +(2^(OUT_W-1)-1) is output as +(2^(OUT_W-1)-1), which is 127 for 8 bits.
- R6: A scaled value below -(2^(OUT_W-1)-1) is output as -(2^(OUT_W-1)-1). The code 100...0 (-128 for 8 bits) is never produced.
- R7: An input accepted on a clock edge (in_valid and in_ready both high) appears on out_llr with out_valid high right after that same edge.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_llr holds its value.
- R9: in_ready is high exactly when the output register is empty or out_ready is high. A transfer out and a transfer in may happen on the same edge.
- R10: With the output register empty and in_valid low, out_valid stays low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input value present |
| in_ready | output | 1 | Block can take an input this cycle |
| in_llr | input | IN_W | Signed fixed-point LLR, FRAC_W fractional bits |
| out_valid | output | 1 | Quantized value present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_llr | output | OUT_W | Signed quantized LLR, one fractional bit |

## Verification
The two events that can fall on the same edge are the output being handed off and a fresh input being loaded into the same register. The bench provokes this by holding in_valid high while toggling out_ready at random, so full-register cycles with out_ready high occur often. The reference model in the bench decides on every clock whether a load, a hold or both should happen. It compares out_valid, out_llr and in_ready each cycle, so a lost or doubled value shows up as a mismatch. Saturation and negative truncation are driven both by a directed list at the clamp edges and by random values weighted toward those edges.

// File: rtl/llr_quant_pkg.sv
// Package: shared constants and helpers for the LLR quantizer.
// Assumes: output widths of at least 2 bits.
package llr_quant_pkg;

    // Largest magnitude kept by the symmetric clamp, for an output of w bits
    function automatic int llr_limit(input int w);
        return (1 << (w - 1)) - 1;
    endfunction

endpackage

// File: rtl/llr_scale_trunc.sv
// Module: llr_scale_trunc
// Doubles a signed fixed-point value and drops its fractional bits,
// truncating toward zero. Purely combinational.
// Assumes: FRAC_W < IN_W. The result is one bit wider than the input,
// so a doubled value never wraps.
module llr_scale_trunc #(
    parameter int IN_W   = 16,
    parameter int FRAC_W = 4
) (
    input  logic signed [IN_W-1:0] din,
    output logic signed [IN_W:0]   dout
);

    localparam int RES_W = IN_W + 1;

    generate
        if (FRAC_W == 0) begin : g_double
            // Integer input: doubling is a left shift by one
            always_comb dout = {din, 1'b0};
        end else if (FRAC_W == 1) begin : g_passthru
            // One fractional bit: doubling yields the integer directly
            always_comb dout = {din[IN_W-1], din};
        end else begin : g_shift
            localparam int SH = FRAC_W - 1;
            logic signed [RES_W-1:0] ext;
            logic                    frac_nz;
            logic                    adj;

            // Sign-extend and check whether any dropped bit is set
            always_comb begin
                ext     = {din[IN_W-1], din};
                frac_nz = |din[SH-1:0];
                adj     = din[IN_W-1] & frac_nz;
            end

            // An arithmetic shift floors; a negative value with a
            // dropped remainder gets one added so it rounds toward zero
            always_comb dout = (ext >>> SH) + $signed({{(RES_W-1){1'b0}}, adj});
        end
    endgenerate

endmodule

// File: rtl/llr_sat_clamp.sv
// Module: llr_sat_clamp
// Saturates a wide signed value into a symmetric narrow range
// [-(2^(OUT_W-1)-1), +(2^(OUT_W-1)-1)], so the most negative code never
// appears. Purely combinational.
// Assumes: W >= OUT_W.
module llr_sat_clamp
    import llr_quant_pkg::*;
#(
    parameter int W     = 17,
    parameter int OUT_W = 8
) (
    input  logic signed [W-1:0]     din,
    output logic signed [OUT_W-1:0] dout
);

    localparam int                  LIM_I = llr_limit(OUT_W);
    localparam logic signed [W-1:0] HI    = W'(LIM_I);
    localparam logic signed [W-1:0] LO    = -HI;

    logic over_hi;
    logic under_lo;

    // Compare against both limits
    always_comb begin
        over_hi  = din > HI;
        under_lo = din < LO;
    end

    // Pick the limit or the in-range low bits
    always_comb begin
        if (over_hi)       dout = HI[OUT_W-1:0];
        else if (under_lo) dout = LO[OUT_W-1:0];
        else               dout = din[OUT_W-1:0];
    end

endmodule

// File: rtl/llr_pipe_reg.sv
// Module: llr_pipe_reg
// Single-entry valid/ready register. It accepts a new word whenever it is
// empty or its content leaves on the same edge.
// Assumes: synchronous active-low reset.
module llr_pipe_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    // Room exists when empty or when the held word is being taken
    always_comb in_ready = !out_valid || out_ready;

    // Load a new word or clear valid when the slot frees up
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) out_data <= in_data;
        end
    end

    // R8: a stalled word stays put
    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R7: an accepted word is visible right after the edge
    a_r7_accept_shows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid && (out_data == $past(in_data)));

    // R10: nothing appears from nothing
    a_r10_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid && !in_valid |=> !out_valid);

endmodule

// File: rtl/llr_quant.sv
// Module: llr_quant (top)
// Converts signed fixed-point channel LLRs into the decoder's narrow
// integer format: doubles the value, truncates toward zero, clamps
// symmetrically, then registers the result behind a valid/ready stage.
// Assumes: FRAC_W < IN_W, OUT_W <= IN_W + 1, synchronous active-low reset.
module llr_quant #(
    parameter int IN_W   = 16,
    parameter int FRAC_W = 4,
    parameter int OUT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic signed [IN_W-1:0]  in_llr,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic signed [OUT_W-1:0] out_llr
);

    localparam int SC_W = IN_W + 1;

    logic signed [SC_W-1:0]  scaled;
    logic signed [OUT_W-1:0] clamped;
    logic        [OUT_W-1:0] held;

    llr_scale_trunc #(
        .IN_W   (IN_W),
        .FRAC_W (FRAC_W)
    ) u_scale (
        .din  (in_llr),
        .dout (scaled)
    );

    llr_sat_clamp #(
        .W     (SC_W),
        .OUT_W (OUT_W)
    ) u_clamp (
        .din  (scaled),
        .dout (clamped)
    );

    llr_pipe_reg #(
        .W (OUT_W)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (clamped),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (held)
    );

    // Present the held word as a signed value
    always_comb out_llr = $signed(held);

    // R6: the most negative code is never emitted
    a_r6_no_min_code: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_llr != $signed({1'b1, {(OUT_W-1){1'b0}}}));

    // R2: a non-negative input never yields a negative output
    a_r2_pos_keeps_sign: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_llr[IN_W-1] |=> !out_llr[OUT_W-1]);

    // R3: a negative input never yields a positive output
    a_r3_neg_not_pos: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_llr[IN_W-1] |=> out_llr <= 0);

endmodule

// File: tb/llr_quant_bench.sv
// Bench for llr_quant: a behavioural per-cycle model compared every clock.
module llr_quant_bench;

    localparam int IN_W   = 16;
    localparam int FRAC_W = 4;
    localparam int OUT_W  = 8;
    localparam int LIM    = 127;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic                    in_ready;
    logic signed [IN_W-1:0]  in_llr = '0;
    logic                    out_valid;
    logic                    out_ready = 1'b0;
    logic signed [OUT_W-1:0] out_llr;

    int  n_cmp  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;

    // model state
    bit    mv   = 1'b0;
    int    md   = 0;
    string mtag = "R7";

    always #2 clk = ~clk;

    llr_quant #(
        .IN_W   (IN_W),
        .FRAC_W (FRAC_W),
        .OUT_W  (OUT_W)
    ) u_llr_quant (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_llr    (in_llr),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_llr   (out_llr)
    );

    function automatic int ref_q(input int v);
        int q;
        if (FRAC_W == 0) q = 2 * v;
        else             q = v / (1 << (FRAC_W - 1));
        if (q > LIM)  q = LIM;
        if (q < -LIM) q = -LIM;
        return q;
    endfunction

    function automatic string ref_tag(input int v);
        int d;
        d = (FRAC_W == 0) ? 1 : (1 << (FRAC_W - 1));
        if (v / d > LIM)  return "R5";
        if (v / d < -LIM) return "R6";
        if (v < 0 && (v % d) == 0) return "R4";
        if (v < 0) return "R3";
        return "R2";
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // At a negedge: compare outputs, then apply stimulus and advance the model
    task automatic step(input bit v, input int d, input bit rdy);
        int vi;
        check(mv ? "R7" : "R10", int'(out_valid), int'(mv));
        if (mv && out_valid) check(mtag, int'(out_llr), md);
        in_valid  = v;
        in_llr    = IN_W'(d);
        out_ready = rdy;
        #0.5;
        check("R9", int'(in_ready), int'(!mv || rdy));
        if (!mv || rdy) begin
            mv = v;
            if (v) begin
                vi   = in_llr;
                md   = ref_q(vi);
                mtag = ref_tag(vi);
            end
        end else begin
            mtag = "R8";
        end
        @(negedge clk);
    endtask

    function automatic int pick_val();
        int r;
        r = int'($urandom_range(0, 5));
        case (r)
            0: return int'($urandom_range(0, 2100)) - 1050;
            1: return int'($urandom_range(0, 40)) - 20;
            2: return int'($urandom_range(1000, 1040));
            3: return -int'($urandom_range(1000, 1040));
            default: return int'($urandom_range(0, 65535)) - 32768;
        endcase
    endfunction

    int dir_vals[] = '{0, 1, 7, 8, 15, 16, 100, -1, -7, -8, -9, -16, -17, -100,
                       1016, 1023, 1024, 2000, 32767,
                       -1016, -1023, -1024, -1032, -32768};

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", int'(out_valid), 0);
        check("R1", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(out_valid), 0);
        check("R1", int'(in_ready), 1);
        mv = 1'b0;
        // directed values, consumer always ready
        foreach (dir_vals[i]) step(1'b1, dir_vals[i], 1'b1);
        // R8: stall over a clamped value, then release
        step(1'b1, -32768, 1'b0);
        step(1'b1, 500, 1'b0);
        step(1'b1, 500, 1'b0);
        step(1'b1, 500, 1'b1);
        // R10: idle
        step(1'b0, 0, 1'b1);
        step(1'b0, 0, 1'b1);
        // random traffic with frequent same-edge hand-off and load (R9)
        for (int k = 0; k < 4000; k++) begin
            step($urandom_range(0, 9) < 7, pick_val(), $urandom_range(0, 9) < 6);
        end
        step(1'b0, 0, 1'b1);
        step(1'b0, 0, 1'b1);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run is counted as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule